// File: doc/BRIEF.md
# Video Stream Capture Writer

This block takes an 8-bit digital video byte stream, clocked by its own pixel clock, and finds the four-byte timing codes that the stream carries. It uses those codes to tell active picture bytes from line and field blanking. Capture is also gated by an external blanking input. That input is looked at only once per line, on the last byte of the end-of-line timing code. Picture bytes that pass are packed four at a time into 32-bit words.

The packed words cross into the system clock domain through a small asynchronous FIFO. A bus master that only writes then stores them to memory. At the start of each frame the write address goes back to a base address. A one-cycle interrupt pulse marks the moment the first word of the new frame is put on the bus. The base address and a capture enable are plain inputs.

Top module: `vcap_top`

## Requirements
- R1: A timing code is the byte sequence FF, 00, 00, XY. In XY, bit 6 is the field bit, bit 5 is the vertical bit and bit 4 selects the code type: 1 means end of active line, 0 means start of active line. Only the bytes after a start-of-line code are picture bytes, and they end at the next FF. Bytes between an end code and the following start code are never captured.
- R2: `vidBlank` is sampled only in the pixel cycle that carries the XY byte of an end-of-line code, and the sampled value holds until the next end-of-line code. A line that follows a sampled high value is not captured. Changes of `vidBlank` at any other time have no effect.
- R3: Each group of four picture bytes becomes one 32-bit word. The first byte goes in bits 7:0 and the fourth in bits 31:24. Packing restarts on every start-of-line code.
- R4: A frame starts at a timing code whose field bit is 0 when the previous code had field bit 1 (the field bit is taken as 1 after reset). No byte is captured before the first frame start after reset. The first word of a frame is written to `baseAddr`, and each later word goes to the previous address plus 4.
- R5: `frameIrq` is a pulse one system clock wide. It is high in the first cycle in which the first word of a new frame is on the bus.
- R6: Every bus transfer is a 32-bit write: `wbWe` is 1 and `wbSel` is 1111. `wbStb` is high only while `wbCyc` is high. Address, data and strobe are held until `wbAck`, and no transfer completes without it.
- R7: While further words are waiting at the moment a transfer is acknowledged, `wbCyc` stays high and the next transfer follows within the same bus cycle.
- R8: While `captureEn` is low, no picture byte is captured.
- R9: The clock-crossing FIFO holds 16 words. A word that completes while the FIFO is full is dropped, and `overflow` rises and stays high until reset. Words already queued are still written, in order.
- R10: After the synchronous active-high reset, `wbCyc`, `wbStb`, `frameIrq` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, also carried into the pixel domain |
| pixClk | input | 1 | Pixel clock of the video stream |
| vidData | input | 8 | Video byte stream |
| vidBlank | input | 1 | External blanking input, sampled at the end-of-line code |
| captureEn | input | 1 | Capture enable |
| baseAddr | input | 32 | Memory address of the first word of a frame |
| wbCyc | output | 1 | Bus cycle active |
| wbStb | output | 1 | Transfer strobe |
| wbWe | output | 1 | Write enable, always 1 |
| wbSel | output | 4 | Byte selects, always all ones |
| wbAdr | output | 32 | Write address |
| wbDat | output | 32 | Write data |
| wbAck | input | 1 | Transfer acknowledge from the memory slave |
| frameIrq | output | 1 | Frame-start interrupt pulse |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
The capture path is driven with complete lines of different lengths and byte seeds. Every written address and data word is compared with a word list built in the bench. This separates correct byte order from a swapped lane, and packing that restarts at the start code from packing that carries over across lines. Fields with the field bit at 1 are sent before and between fields at 0. This shows that nothing is stored before lock and that the address returns to a changed base address at a frame start, not at every line. Blanking is driven high once only on the end-code XY byte and once only through the picture bytes, which tells the single sampling point apart from a level-sensitive gate. Stalling the acknowledge while a long line arrives tells apart a bus cycle that is held across queued words, the exact number of words kept before the FIFO fills, and a sticky overflow flag from one that clears itself.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  localparam int unsigned BYTE_W = 8;

  // Control-to-datapath strobes in the pixel domain
  typedef struct packed {
    logic lineStart;    // start-of-line code seen: restart packing
    logic captureByte;  // current byte is a qualified picture byte
    logic markFrame;    // field bit fell: tag the next word as frame start
  } vcapStrobes_t;

endpackage

// File: rtl/vcap_async_fifo.sv
module vcap_async_fifo #(
  parameter int unsigned WIDTH = 33,
  parameter int unsigned DEPTH = 16
) (
  input  logic             wrClk,
  input  logic             wrRst,
  input  logic             wrPush,
  input  logic [WIDTH-1:0] wrData,
  output logic             wrFull,
  input  logic             rdClk,
  input  logic             rdRst,
  input  logic             rdPop,
  output logic [WIDTH-1:0] rdData,
  output logic             rdEmpty
);

  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W:0] wrBin, wrGray, rdBin, rdGray;
  logic [PTR_W:0] rdGrayS1, rdGrayS2, wrGrayS1, wrGrayS2;
  logic [PTR_W:0] wrBinNext, rdBinNext;

  assign wrBinNext = wrBin + 1'b1;
  assign rdBinNext = rdBin + 1'b1;

  // write side
  always_ff @(posedge wrClk) begin
    if (wrPush && !wrFull) mem[wrBin[PTR_W-1:0]] <= wrData;
  end

  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (wrPush && !wrFull) begin
        wrBin  <= wrBinNext;
        wrGray <= wrBinNext ^ (wrBinNext >> 1);
      end
    end
  end

  assign wrFull = (wrGray == {~rdGrayS2[PTR_W:PTR_W-1], rdGrayS2[PTR_W-2:0]});

  // read side
  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
      if (rdPop && !rdEmpty) begin
        rdBin  <= rdBinNext;
        rdGray <= rdBinNext ^ (rdBinNext >> 1);
      end
    end
  end

  assign rdEmpty = (rdGray == wrGrayS2);
  assign rdData  = mem[rdBin[PTR_W-1:0]];

  // R9
  pop_when_data_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    rdPop |-> !rdEmpty)
    else $error("pop_when_data_chk");

endmodule

// File: rtl/vcap_pix_ctrl.sv
module vcap_pix_ctrl
  import vcap_pkg::*;
(
  input  logic              pixClk,
  input  logic              pixRst,
  input  logic [BYTE_W-1:0] vidData,
  input  logic              vidBlank,
  input  logic              captureEn,
  output logic [BYTE_W-1:0] pixByte,
  output vcapStrobes_t      strobes
);

  localparam logic [BYTE_W-1:0] CODE_HI = '1;
  localparam logic [BYTE_W-1:0] CODE_LO = '0;

  logic [BYTE_W-1:0] hist1, hist2, hist3;
  logic blankQ;
  logic [1:0] enPipe;
  logic inActive, blankHeld, prevField, locked;
  logic codeHit, xyField, xyEnd;

  // input register and three-byte history
  always_ff @(posedge pixClk) begin
    if (pixRst) begin
      pixByte <= '0;
      hist1   <= '0;
      hist2   <= '0;
      hist3   <= '0;
      blankQ  <= 1'b0;
      enPipe  <= '0;
    end else begin
      pixByte <= vidData;
      blankQ  <= vidBlank;
      hist1   <= pixByte;
      hist2   <= hist1;
      hist3   <= hist2;
      enPipe  <= {enPipe[0], captureEn};
    end
  end

  assign codeHit = (hist3 == CODE_HI) && (hist2 == CODE_LO) && (hist1 == CODE_LO);
  assign xyField = pixByte[6];
  assign xyEnd   = pixByte[4];

  always_ff @(posedge pixClk) begin
    if (pixRst) begin
      inActive  <= 1'b0;
      blankHeld <= 1'b0;
      prevField <= 1'b1;
      locked    <= 1'b0;
    end else if (codeHit) begin
      prevField <= xyField;
      if (prevField && !xyField) locked <= 1'b1;
      if (xyEnd) blankHeld <= blankQ;
      else       inActive  <= 1'b1;
    end else if (pixByte == CODE_HI) begin
      inActive <= 1'b0;
    end
  end

  always_comb begin
    strobes.lineStart   = codeHit && !xyEnd;
    strobes.markFrame   = codeHit && prevField && !xyField;
    strobes.captureByte = inActive && (pixByte != CODE_HI) && !blankHeld
                          && locked && enPipe[1];
  end

endmodule

// File: rtl/vcap_pix_datapath.sv
module vcap_pix_datapath
  import vcap_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic                         pixClk,
  input  logic                         pixRst,
  input  logic [BYTE_W-1:0]            pixByte,
  input  vcapStrobes_t                 strobes,
  input  logic                         fifoFull,
  output logic                         fifoPush,
  output logic [WORD_BYTES*BYTE_W:0]   fifoData,
  output logic                         overflowFlag
);

  localparam int unsigned WORD_W = WORD_BYTES * BYTE_W;
  localparam int unsigned CNT_W  = $clog2(WORD_BYTES);
  localparam logic [CNT_W-1:0] LAST_LANE = CNT_W'(WORD_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;
  logic [BYTE_W-1:0] laneReg [WORD_BYTES-1];
  logic frameTag, lastByte;
  logic [WORD_W-1:0] packedWord;

  assign lastByte = strobes.captureByte && (byteCnt == LAST_LANE);
  assign fifoPush = lastByte && !fifoFull;

  // one register per lower byte lane
  for (genvar lane = 0; lane < WORD_BYTES - 1; lane++) begin : g_lane
    always_ff @(posedge pixClk) begin
      if (pixRst) laneReg[lane] <= '0;
      else if (strobes.captureByte && byteCnt == CNT_W'(lane)) laneReg[lane] <= pixByte;
    end
    assign packedWord[lane*BYTE_W +: BYTE_W] = laneReg[lane];
  end
  assign packedWord[WORD_W-1 -: BYTE_W] = pixByte;

  assign fifoData = {frameTag, packedWord};

  always_ff @(posedge pixClk) begin
    if (pixRst) begin
      byteCnt      <= '0;
      frameTag     <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      if (strobes.lineStart)        byteCnt <= '0;
      else if (lastByte)            byteCnt <= '0;
      else if (strobes.captureByte) byteCnt <= byteCnt + 1'b1;
      if (fifoPush)          frameTag <= 1'b0;
      if (strobes.markFrame) frameTag <= 1'b1;
      if (lastByte && fifoFull) overflowFlag <= 1'b1;
    end
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge pixClk) disable iff (pixRst)
    overflowFlag |=> overflowFlag)
    else $error("ovf_sticky_chk");

endmodule

// File: rtl/vcap_wb_writer.sv
module vcap_wb_writer #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic                rdTag,
  input  logic [DATA_W-1:0]   rdWord,
  input  logic                rdEmpty,
  output logic                rdPop,
  output logic                wbCyc,
  output logic                wbStb,
  output logic                wbWe,
  output logic [DATA_W/8-1:0] wbSel,
  output logic [ADDR_W-1:0]   wbAdr,
  output logic [DATA_W-1:0]   wbDat,
  input  logic                wbAck,
  output logic                frameIrq
);

  localparam int unsigned SEL_W = DATA_W / 8;
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(SEL_W);

  logic [ADDR_W-1:0] nextAddr, loadAddr;
  logic slotFree;

  assign slotFree = !wbCyc || wbAck;
  assign rdPop    = slotFree && !rdEmpty;
  assign loadAddr = rdTag ? baseAddr : nextAddr;
  assign wbWe     = 1'b1;
  assign wbSel    = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbCyc    <= 1'b0;
      wbStb    <= 1'b0;
      wbAdr    <= '0;
      wbDat    <= '0;
      nextAddr <= '0;
      frameIrq <= 1'b0;
    end else begin
      frameIrq <= 1'b0;
      if (rdPop) begin
        wbCyc    <= 1'b1;
        wbStb    <= 1'b1;
        wbAdr    <= loadAddr;
        wbDat    <= rdWord;
        nextAddr <= loadAddr + ADDR_STEP;
        frameIrq <= rdTag;
      end else if (wbCyc && wbAck) begin
        wbCyc <= 1'b0;
        wbStb <= 1'b0;
      end
    end
  end

  // R6
  stb_in_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    wbStb |-> wbCyc)
    else $error("stb_in_cyc_chk");

  // R6
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (wbStb && !wbAck) |=> (wbStb && $stable(wbAdr) && $stable(wbDat)))
    else $error("hold_until_ack_chk");

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frameIrq |=> !frameIrq)
    else $error("irq_pulse_chk");

  // R5
  irq_on_transfer_chk: assert property (@(posedge clk) disable iff (rst)
    frameIrq |-> (wbStb && wbAdr == $past(baseAddr)))
    else $error("irq_on_transfer_chk");

endmodule

// File: rtl/vcap_top.sv
module vcap_top
  import vcap_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned ADDR_W     = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           pixClk,
  input  logic [BYTE_W-1:0]              vidData,
  input  logic                           vidBlank,
  input  logic                           captureEn,
  input  logic [ADDR_W-1:0]              baseAddr,
  output logic                           wbCyc,
  output logic                           wbStb,
  output logic                           wbWe,
  output logic [WORD_BYTES-1:0]          wbSel,
  output logic [ADDR_W-1:0]              wbAdr,
  output logic [WORD_BYTES*BYTE_W-1:0]   wbDat,
  input  logic                           wbAck,
  output logic                           frameIrq,
  output logic                           overflow
);

  localparam int unsigned WORD_W  = WORD_BYTES * BYTE_W;
  localparam int unsigned ENTRY_W = WORD_W + 1;

  logic [1:0] pixRstPipe, ovfPipe;
  logic pixRst, pixOverflow;
  logic [BYTE_W-1:0] pixByte;
  vcapStrobes_t strobes;
  logic fifoPush, fifoFull, fifoPop, fifoEmpty;
  logic [ENTRY_W-1:0] fifoIn, fifoOut;

  // reset carried into the pixel domain
  always_ff @(posedge pixClk) pixRstPipe <= {pixRstPipe[0], rst};
  assign pixRst = pixRstPipe[1];

  // overflow flag carried into the system domain
  always_ff @(posedge clk) begin
    if (rst) ovfPipe <= '0;
    else     ovfPipe <= {ovfPipe[0], pixOverflow};
  end
  assign overflow = ovfPipe[1];

  vcap_pix_ctrl i_ctrl (
    .pixClk    (pixClk),
    .pixRst    (pixRst),
    .vidData   (vidData),
    .vidBlank  (vidBlank),
    .captureEn (captureEn),
    .pixByte   (pixByte),
    .strobes   (strobes)
  );

  vcap_pix_datapath #(.WORD_BYTES(WORD_BYTES)) i_datapath (
    .pixClk       (pixClk),
    .pixRst       (pixRst),
    .pixByte      (pixByte),
    .strobes      (strobes),
    .fifoFull     (fifoFull),
    .fifoPush     (fifoPush),
    .fifoData     (fifoIn),
    .overflowFlag (pixOverflow)
  );

  vcap_async_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .wrClk   (pixClk),
    .wrRst   (pixRst),
    .wrPush  (fifoPush),
    .wrData  (fifoIn),
    .wrFull  (fifoFull),
    .rdClk   (clk),
    .rdRst   (rst),
    .rdPop   (fifoPop),
    .rdData  (fifoOut),
    .rdEmpty (fifoEmpty)
  );

  vcap_wb_writer #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) i_writer (
    .clk      (clk),
    .rst      (rst),
    .baseAddr (baseAddr),
    .rdTag    (fifoOut[ENTRY_W-1]),
    .rdWord   (fifoOut[WORD_W-1:0]),
    .rdEmpty  (fifoEmpty),
    .rdPop    (fifoPop),
    .wbCyc    (wbCyc),
    .wbStb    (wbStb),
    .wbWe     (wbWe),
    .wbSel    (wbSel),
    .wbAdr    (wbAdr),
    .wbDat    (wbDat),
    .wbAck    (wbAck),
    .frameIrq (frameIrq)
  );

endmodule

// File: tb/test_vcap_top.sv
module test_vcap_top;

  logic clk = 1'b0, rst = 1'b1, pixClk = 1'b0;
  logic [7:0] vidData = 8'h00;
  logic vidBlank = 1'b0, captureEn = 1'b1, wbAck = 1'b0;
  logic [31:0] baseAddr = 32'h1000_0000;
  logic wbCyc, wbStb, wbWe, frameIrq, overflow;
  logic [3:0] wbSel;
  logic [31:0] wbAdr, wbDat;

  vcap_top i_vcap_top (
    .clk(clk), .rst(rst), .pixClk(pixClk), .vidData(vidData), .vidBlank(vidBlank),
    .captureEn(captureEn), .baseAddr(baseAddr), .wbCyc(wbCyc), .wbStb(wbStb),
    .wbWe(wbWe), .wbSel(wbSel), .wbAdr(wbAdr), .wbDat(wbDat), .wbAck(wbAck),
    .frameIrq(frameIrq), .overflow(overflow)
  );

  always #10 clk = ~clk;      // 50 MHz system clock
  always #19 pixClk = ~pixClk;

  int checks = 0, errors = 0;
  bit done = 0;

  // slave model and bus log
  logic [31:0] logAdr [256];
  logic [31:0] logDat [256];
  int logCnt = 0, irqCnt = 0, irqIdx = -1, cycRise = 0, badAttr = 0;
  logic cycPrev = 1'b0;
  bit stall = 0;

  always @(posedge clk) begin
    if (rst) begin
      wbAck   <= 1'b0;
      cycPrev <= 1'b0;
    end else begin
      if (wbCyc && wbStb && wbAck) begin
        if (logCnt < 256) begin
          logAdr[logCnt] = wbAdr;
          logDat[logCnt] = wbDat;
        end
        logCnt++;
      end
      if (wbCyc && wbStb && (wbWe !== 1'b1 || wbSel !== 4'hF)) badAttr++;
      if (frameIrq) begin
        irqCnt++;
        irqIdx = logCnt;
      end
      if (wbCyc && !cycPrev) cycRise++;
      cycPrev <= wbCyc;
      wbAck   <= wbCyc && wbStb && !wbAck && !stall;
    end
  end

  // expected word list
  logic [31:0] expAdr [256];
  logic [31:0] expDat [256];
  int expCnt = 0, cmpIdx = 0;
  logic [31:0] modelAddr = 32'h0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] xyByte(bit f, bit v, bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] actByte(int seed, int i);
    return 8'(32 + ((seed * 37 + i * 5) % 192));
  endfunction

  task automatic waitSys(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sendByte(logic [7:0] b, logic bl);
    @(negedge pixClk);
    vidData  = b;
    vidBlank = bl;
  endtask

  // start code, picture bytes, end code (blank sample), filler
  task automatic sendLine(bit f, int nBytes, int seed, int expWords, bit blankNext, bit midBlank);
    sendByte(8'hFF, 1'b0); sendByte(8'h00, 1'b0); sendByte(8'h00, 1'b0);
    sendByte(xyByte(f, 1'b0, 1'b0), 1'b0);
    for (int i = 0; i < nBytes; i++) sendByte(actByte(seed, i), midBlank);
    sendByte(8'hFF, 1'b0); sendByte(8'h00, 1'b0); sendByte(8'h00, 1'b0);
    sendByte(xyByte(f, 1'b0, 1'b1), blankNext);
    for (int i = 0; i < 4; i++) sendByte((i % 2 == 0) ? 8'h80 : 8'h10, 1'b0);
    for (int w = 0; w < expWords; w++) begin
      expAdr[expCnt] = modelAddr;
      expDat[expCnt] = {actByte(seed, 4*w+3), actByte(seed, 4*w+2),
                        actByte(seed, 4*w+1), actByte(seed, 4*w)};
      expCnt++;
      modelAddr += 32'd4;
    end
  endtask

  task automatic compareLog(string req);
    @(negedge clk);
    check(logCnt == expCnt, req, "word count", 32'(logCnt), 32'(expCnt));
    for (int k = cmpIdx; k < expCnt && k < logCnt; k++) begin
      check(logAdr[k] == expAdr[k], req, $sformatf("address of word %0d", k), logAdr[k], expAdr[k]);
      check(logDat[k] == expDat[k], req, $sformatf("data of word %0d", k), logDat[k], expDat[k]);
    end
    cmpIdx = expCnt;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!wbCyc, "R10", "wbCyc after reset", 32'(wbCyc), 0);
    check(!wbStb, "R10", "wbStb after reset", 32'(wbStb), 0);
    check(!frameIrq, "R10", "frameIrq after reset", 32'(frameIrq), 0);
    check(!overflow, "R10", "overflow after reset", 32'(overflow), 0);
  endtask

  task automatic t_prelock();
    sendLine(1'b1, 8, 1, 0, 1'b0, 1'b0);
    sendLine(1'b1, 8, 2, 0, 1'b0, 1'b0);
    waitSys(100);
    @(negedge clk);
    check(logCnt == 0, "R4", "writes before first frame start", 32'(logCnt), 0);
    check(irqCnt == 0, "R5", "interrupts before first frame start", 32'(irqCnt), 0);
  endtask

  task automatic t_firstFrame();
    int startIdx;
    modelAddr = baseAddr;
    startIdx  = expCnt;
    sendLine(1'b0, 8, 3, 2, 1'b0, 1'b0);
    sendLine(1'b0, 12, 4, 3, 1'b0, 1'b0);
    waitSys(100);
    compareLog("R1/R3/R4");
    check(irqCnt == 1, "R5", "interrupt count at first frame", 32'(irqCnt), 1);
    check(irqIdx == startIdx, "R5", "interrupt word index", 32'(irqIdx), 32'(startIdx));
  endtask

  task automatic t_blanking();
    sendLine(1'b0, 8, 5, 2, 1'b1, 1'b0);  // its end code samples blanking high
    sendLine(1'b0, 8, 6, 0, 1'b0, 1'b0);  // dropped line
    sendLine(1'b0, 8, 7, 2, 1'b0, 1'b1);  // blanking high only mid-line: kept
    waitSys(100);
    compareLog("R2");
    check(badAttr == 0, "R6", "transfers not full-width writes", 32'(badAttr), 0);
  endtask

  task automatic t_enable();
    captureEn = 1'b0;
    waitSys(10);
    sendLine(1'b0, 8, 8, 0, 1'b0, 1'b0);
    waitSys(100);
    compareLog("R8");
    captureEn = 1'b1;
    waitSys(10);
  endtask

  task automatic t_newFrame();
    int startIdx;
    baseAddr = 32'h2000_0400;
    sendLine(1'b1, 8, 9, 2, 1'b0, 1'b0);   // second field continues
    modelAddr = baseAddr;
    startIdx  = expCnt;
    sendLine(1'b0, 8, 10, 2, 1'b0, 1'b0);  // field bit falls: restart
    waitSys(100);
    compareLog("R4");
    check(irqCnt == 2, "R5", "interrupt count at second frame", 32'(irqCnt), 2);
    check(irqIdx == startIdx, "R5", "second interrupt word index", 32'(irqIdx), 32'(startIdx));
  endtask

  task automatic t_burst();
    int rise0;
    @(negedge clk);
    stall = 1;
    rise0 = cycRise;
    sendLine(1'b0, 32, 11, 8, 1'b0, 1'b0);
    waitSys(60);
    @(negedge clk);
    check(logCnt == cmpIdx, "R6", "transfers completed without acknowledge", 32'(logCnt), 32'(cmpIdx));
    stall = 0;
    waitSys(100);
    compareLog("R7");
    check(cycRise - rise0 == 1, "R7", "bus cycles for queued burst", 32'(cycRise - rise0), 1);
  endtask

  task automatic t_overflow();
    @(negedge clk);
    stall = 1;
    sendLine(1'b0, 80, 12, 17, 1'b0, 1'b0);
    waitSys(60);
    @(negedge clk);
    check(overflow, "R9", "overflow after FIFO filled", 32'(overflow), 1);
    stall = 0;
    waitSys(200);
    compareLog("R9");
    check(overflow, "R9", "overflow stays set", 32'(overflow), 1);
  endtask

  task automatic t_resetClear();
    @(negedge clk);
    rst = 1'b1;
    waitSys(10);
    @(negedge clk);
    rst = 1'b0;
    waitSys(5);
    @(negedge clk);
    check(!overflow, "R10", "overflow cleared by reset", 32'(overflow), 0);
    check(!wbCyc, "R10", "wbCyc after second reset", 32'(wbCyc), 0);
  endtask

  initial begin
    waitSys(10);
    @(negedge clk);
    rst = 1'b0;
    waitSys(5);
    t_reset();
    t_prelock();
    t_firstFrame();
    t_blanking();
    t_enable();
    t_newFrame();
    t_burst();
    t_overflow();
    t_resetClear();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule